// File: doc/BRIEF.md
# JTAG Mass-Erase Command Sequencer

This block is a host-side JTAG master. A single start pulse makes it drive the test clock, mode-select and data-in pins of one target TAP. It runs a fixed script that wipes the whole flash array of a locked part. The script resets the TAP and reads the 32-bit identification word through a data-register scan with zero fill. It then selects the tap-link path, writes the chip-select field, selects the flash test data register and raises the erase-all request bit. After a programmable hold it writes the request bit back to zero. No status is polled between those two writes. The only guarantee is that the clearing write lands inside a fixed time window after the asserting one.

The test clock comes from the system clock through a parameterised half-period divider. Outgoing pins change only as the test clock falls, and the returned data bit is taken as it rises. An optional identity check ends the run after the ID scan, with no erase, if the word read back differs from the expected value. The captured word stays on `id_o` until the next accepted start, which clears it.

Top module: `flash_wipe_jtag`

## Requirements
- R1: While reset is held, and whenever no run is active, `tck_o` is high and `busy_o` and `done_o` are low. Reset clears `id_o` to zero.
- R2: Each run begins with at least five test clocks with TMS high. This forces the target TAP into Test-Logic-Reset before any scan, from any starting state.
- R3: The first scan is a 32-bit data-register scan with all TDI bits zero. The bits returned on TDO are assembled least significant bit first into the identification word.
- R4: The second scan is an 8-bit instruction scan of value 0x05, selecting the link path. The third is a 4-bit data scan of value 0x1, the chip select. All scans shift the least significant bit first.
- R5: The fourth scan is an 8-bit instruction scan of value 0x09, selecting the flash test data register.
- R6: The fifth scan is a 16-bit data scan of value 0x0001, raising the erase request. The sixth and last is a 16-bit data scan of value 0x0000, clearing it.
- R7: After the ID scan, `id_o` holds the word read back until the next accepted start. The start clears it to zero.
- R8: The Update-DR of the clearing scan comes no fewer than HOLD_CYC system clocks after the Update-DR of the asserting scan. It comes no more than HOLD_CYC plus 30 test-clock periods after it. Elaboration rejects a HOLD_CYC whose window does not fit inside 6 us to 16 ms.
- R9: After the last scan the TAP is left in Run-Test/Idle. `done_o` then pulses high for exactly one system clock, in the same cycle that `busy_o` falls.
- R10: A start pulse that arrives while `busy_o` is high is ignored. It adds no scan and no extra done pulse.
- R11: With the identity check on, a mismatch between the ID read back and the expected word ends the run after the ID scan returns to Run-Test/Idle. No further scan is issued and `done_o` still pulses once.
- R12: A start presented in the cycle that `done_o` is high is accepted. `busy_o` is high in the next cycle and a complete new script follows.
- R13: TMS and TDI change only in the cycle where `tck_o` goes from high to low. They never change while `tck_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to run the erase script |
| busy_o | output | 1 | High while a script run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| id_o | output | ID_W | Identification word read in the first scan |
| tck_o | output | 1 | Test clock to the target |
| tms_o | output | 1 | Test mode select to the target |
| tdi_o | output | 1 | Test data to the target |
| tdo_i | input | 1 | Test data from the target |

## Verification
Two functions can land in the same cycle: the one-cycle completion pulse that ends a run, and the acceptance of a new start. The bench provokes this by raising `start_i` in the very cycle it sees `done_o` high. It then requires that `busy_o` is high one cycle later and that `id_o` has been cleared. A scoreboard must also see twelve scans in script order with exactly two done pulses for the pair of runs. A second, weaker collision is a start arriving mid-run. It is judged by the absence of any extra scan or done pulse.

// File: rtl/fwj_pkg.sv
package fwj_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_RESET,
      PH_HEAD,
      PH_SHIFT,
      PH_TAIL,
      PH_HOLD
   } phase_e;

   localparam int unsigned LEN_W     = 6;
   localparam int unsigned SCAN_MAXW = 32;

   localparam logic [2:0] STEP_ID  = 3'd0;
   localparam logic [2:0] STEP_SET = 3'd4;
   localparam logic [2:0] STEP_CLR = 3'd5;

   localparam logic [7:0]  LINK_IR   = 8'h05;
   localparam logic [3:0]  CHIP_SEL  = 4'h1;
   localparam logic [7:0]  FLASH_IR  = 8'h09;
   localparam logic [15:0] WIPE_ON   = 16'h0001;
   localparam logic [15:0] WIPE_OFF  = 16'h0000;

   typedef struct packed {
      logic                 is_ir;
      logic [LEN_W-1:0]     len;
      logic [SCAN_MAXW-1:0] data;
   } scan_t;

   function automatic scan_t script_entry(input logic [2:0] idx, input int unsigned id_w);
      scan_t s;
      s = '{is_ir: 1'b0, len: LEN_W'(1), data: '0};
      unique case (idx)
         3'd0: s = '{is_ir: 1'b0, len: LEN_W'(id_w), data: '0};
         3'd1: s = '{is_ir: 1'b1, len: LEN_W'(8),    data: SCAN_MAXW'(LINK_IR)};
         3'd2: s = '{is_ir: 1'b0, len: LEN_W'(4),    data: SCAN_MAXW'(CHIP_SEL)};
         3'd3: s = '{is_ir: 1'b1, len: LEN_W'(8),    data: SCAN_MAXW'(FLASH_IR)};
         3'd4: s = '{is_ir: 1'b0, len: LEN_W'(16),   data: SCAN_MAXW'(WIPE_ON)};
         3'd5: s = '{is_ir: 1'b0, len: LEN_W'(16),   data: SCAN_MAXW'(WIPE_OFF)};
         default: s = '{is_ir: 1'b0, len: LEN_W'(1), data: '0};
      endcase
      return s;
   endfunction

endpackage

// File: rtl/fwj_tck_gen.sv
module fwj_tck_gen #(
   parameter int unsigned HALF = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   output logic tck_o,
   output logic fall_o,
   output logic rise_o
);
   localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;

   logic [CW-1:0] cnt_q;
   logic          tck_q;
   logic          wrap;

   assign wrap = en_i && (cnt_q == CW'(HALF - 1));

   always_ff @(posedge clk_i) begin
      if (!rst_ni || !en_i) begin
         cnt_q <= '0;
         tck_q <= 1'b1;
      end else if (wrap) begin
         cnt_q <= '0;
         tck_q <= ~tck_q;
      end else begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   assign tck_o  = tck_q;
   assign fall_o = wrap & tck_q;
   assign rise_o = wrap & ~tck_q;
endmodule

// File: rtl/fwj_hold_timer.sv
module fwj_hold_timer #(
   parameter int unsigned HOLD_CYC = 400
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   output logic expired_o
);
   localparam int unsigned W = $clog2(HOLD_CYC + 1);

   logic [W-1:0] cnt_q;

   assign expired_o = (cnt_q == W'(HOLD_CYC));

   always_ff @(posedge clk_i) begin
      if (!rst_ni || !run_i) begin
         cnt_q <= '0;
      end else if (!expired_o) begin
         cnt_q <= cnt_q + W'(1);
      end
   end
endmodule

// File: rtl/fwj_id_cap.sv
module fwj_id_cap #(
   parameter int unsigned     ID_W      = 32,
   parameter bit              CHECK_ID  = 1'b1,
   parameter logic [ID_W-1:0] EXPECT_ID = ID_W'(32'h16B4801D)
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            clear_i,
   input  logic            shift_i,
   input  logic            tdo_i,
   output logic [ID_W-1:0] id_o,
   output logic            bad_o
);
   logic [ID_W-1:0] sh_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni || clear_i) begin
         sh_q <= '0;
      end else if (shift_i) begin
         if (ID_W > 1) sh_q <= {tdo_i, sh_q[ID_W-1:1]};
         else          sh_q <= ID_W'(tdo_i);
      end
   end

   assign id_o = sh_q;

   generate
      if (CHECK_ID) begin : g_check
         assign bad_o = (sh_q != EXPECT_ID);
      end else begin : g_nocheck
         assign bad_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/flash_wipe_jtag.sv
module flash_wipe_jtag
   import fwj_pkg::*;
#(
   parameter int unsigned     CLK_HZ    = 50_000_000,
   parameter int unsigned     TCK_HALF  = 2,
   parameter int unsigned     HOLD_CYC  = 400,
   parameter int unsigned     ID_W      = 32,
   parameter bit              CHECK_ID  = 1'b1,
   parameter logic [ID_W-1:0] EXPECT_ID = ID_W'(32'h16B4801D)
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            start_i,
   output logic            busy_o,
   output logic            done_o,
   output logic [ID_W-1:0] id_o,
   output logic            tck_o,
   output logic            tms_o,
   output logic            tdi_o,
   input  logic            tdo_i
);
   localparam longint MIN_HOLD  = (longint'(CLK_HZ) * 6 + 64'd999_999) / 64'd1_000_000;
   localparam longint MAX_SPAN  = (longint'(CLK_HZ) * 16) / 64'd1_000;
   localparam longint TAIL_SPAN = 64'd60 * longint'(TCK_HALF);
   localparam int unsigned RESET_TICKS = 6;

   generate
      if (TCK_HALF < 1) begin : g_bad_half
         $error("TCK_HALF must be at least one system clock");
      end
      if (ID_W < 1 || ID_W > SCAN_MAXW) begin : g_bad_idw
         $error("ID_W must lie between 1 and 32");
      end
      if (longint'(HOLD_CYC) < MIN_HOLD) begin : g_hold_short
         $error("HOLD_CYC is shorter than the 6 us minimum");
      end
      if (longint'(HOLD_CYC) + TAIL_SPAN > MAX_SPAN) begin : g_hold_long
         $error("HOLD_CYC plus scan time exceeds the 16 ms limit");
      end
   endgenerate

   phase_e           ph_q, ph_n;
   logic [2:0]       step_q, step_n;
   logic [LEN_W-1:0] cnt_q, cnt_n;
   logic             busy_q, done_q;
   logic             tms_q, tms_n, tdi_q, tdi_n;
   logic             last_q, last_n;
   logic             idsh_q, idsh_n;
   logic             fall, rise, hold_exp, id_bad, accept;
   scan_t            cur;
   logic [LEN_W-1:0] head_len;

   fwj_tck_gen #(.HALF(TCK_HALF)) u_tck (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (busy_q),
      .tck_o (tck_o),
      .fall_o(fall),
      .rise_o(rise)
   );

   fwj_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (ph_q == PH_HOLD),
      .expired_o(hold_exp)
   );

   fwj_id_cap #(.ID_W(ID_W), .CHECK_ID(CHECK_ID), .EXPECT_ID(EXPECT_ID)) u_id (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clear_i(accept),
      .shift_i(rise && idsh_q),
      .tdo_i  (tdo_i),
      .id_o   (id_o),
      .bad_o  (id_bad)
   );

   assign accept   = start_i && !busy_q;
   assign cur      = script_entry(step_q, ID_W);
   assign head_len = cur.is_ir ? LEN_W'(4) : LEN_W'(3);

   // Next tick: pin values launched at the coming falling edge and the state after it.
   always_comb begin
      ph_n   = ph_q;
      step_n = step_q;
      cnt_n  = cnt_q + LEN_W'(1);
      tms_n  = 1'b0;
      tdi_n  = 1'b0;
      last_n = 1'b0;
      idsh_n = 1'b0;
      unique case (ph_q)
         PH_RESET: begin
            tms_n = (cnt_q != LEN_W'(RESET_TICKS - 1));
            if (cnt_q == LEN_W'(RESET_TICKS - 1)) begin
               ph_n   = PH_HEAD;
               step_n = STEP_ID;
               cnt_n  = '0;
            end
         end
         PH_HEAD: begin
            tms_n = cur.is_ir ? (cnt_q < LEN_W'(2)) : (cnt_q == '0);
            if (cnt_q == head_len - LEN_W'(1)) begin
               ph_n  = PH_SHIFT;
               cnt_n = '0;
            end
         end
         PH_SHIFT: begin
            tdi_n  = cur.data[cnt_q[4:0]];
            tms_n  = (cnt_q == cur.len - LEN_W'(1));
            idsh_n = (step_q == STEP_ID);
            if (cnt_q == cur.len - LEN_W'(1)) begin
               ph_n  = PH_TAIL;
               cnt_n = '0;
            end
         end
         PH_TAIL: begin
            tms_n = (cnt_q == '0);
            if (cnt_q == LEN_W'(1)) begin
               cnt_n = '0;
               if (step_q == STEP_CLR || (step_q == STEP_ID && id_bad)) begin
                  last_n = 1'b1;
                  ph_n   = PH_IDLE;
               end else if (step_q == STEP_SET) begin
                  ph_n = PH_HOLD;
               end else begin
                  ph_n   = PH_HEAD;
                  step_n = step_q + 3'd1;
               end
            end
         end
         PH_HOLD: begin
            cnt_n = '0;
            if (hold_exp) begin
               ph_n   = PH_HEAD;
               step_n = STEP_CLR;
            end
         end
         default: begin
            cnt_n = cnt_q;
         end
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ph_q   <= PH_IDLE;
         step_q <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
         tms_q  <= 1'b1;
         tdi_q  <= 1'b0;
         last_q <= 1'b0;
         idsh_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start_i) begin
               busy_q <= 1'b1;
               ph_q   <= PH_RESET;
               step_q <= '0;
               cnt_q  <= '0;
               last_q <= 1'b0;
            end
         end else begin
            if (fall) begin
               ph_q   <= ph_n;
               step_q <= step_n;
               cnt_q  <= cnt_n;
               tms_q  <= tms_n;
               tdi_q  <= tdi_n;
               last_q <= last_n;
               idsh_q <= idsh_n;
            end
            if (rise && last_q) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               last_q <= 1'b0;
               idsh_q <= 1'b0;
            end
         end
      end
   end

   assign busy_o = busy_q;
   assign done_o = done_q;
   assign tms_o  = tms_q;
   assign tdi_o  = tdi_q;
endmodule

// File: rtl/fwj_chk.sv
module fwj_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic start_i,
   input logic busy_o,
   input logic done_o,
   input logic tck_o,
   input logic tms_o,
   input logic tdi_o
);
   // R1
   tck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> tck_o);

   // R9
   done_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !busy_o);

   // R9
   done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   // R10
   busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_o) |-> $past(start_i));

   // R13
   pins_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tck_o |-> ($stable(tms_o) && $stable(tdi_o)));
endmodule

bind flash_wipe_jtag fwj_chk u_fwj_chk (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .start_i(start_i),
   .busy_o (busy_o),
   .done_o (done_o),
   .tck_o  (tck_o),
   .tms_o  (tms_o),
   .tdi_o  (tdi_o)
);

// File: tb/flash_wipe_jtag_tb_top.sv
`timescale 1ns/1ps
module flash_wipe_jtag_tb_top;
   localparam int unsigned HALF = 2;
   localparam int unsigned HOLD = 400;
   localparam logic [31:0] GOOD_ID = 32'h16B4801D;
   localparam logic [31:0] BAD_ID  = 32'h2468ACE1;

   localparam int TLR = 0, RTI = 1, SELDR = 2, CAPDR = 3, SHDR = 4, EX1DR = 5, PSDR = 6, EX2DR = 7,
                  UPDR = 8, SELIR = 9, CAPIR = 10, SHIR = 11, EX1IR = 12, PSIR = 13, EX2IR = 14, UPIR = 15;

   typedef struct {
      bit          is_ir;
      int          len;
      logic [31:0] val;
      string       req;
   } scan_item_t;

   logic        clk_i = 1'b0;
   logic        rst_ni;
   logic        start_i;
   logic        busy_o, done_o, tck_o, tms_o, tdi_o;
   logic        tdo_i = 1'b0;
   logic [31:0] id_o;

   int          n_chk = 0, n_bad = 0;
   longint      cyc = 0;
   scan_item_t  exp_q[$];
   logic [31:0] model_id;
   int          tap_st = SELIR;
   logic [31:0] dsh = '0;
   int          dn = 0;
   bit          armed = 0, id_sel = 1;
   int          tlr_hits = 0, scan_cnt = 0, done_cnt = 0, pin_bad = 0;
   longint      t_set = 0, t_clr = 0;
   logic        prev_tms = 1'b1, prev_tdi = 1'b0;

   always #10 clk_i = ~clk_i;

   flash_wipe_jtag #(
      .CLK_HZ(50_000_000), .TCK_HALF(HALF), .HOLD_CYC(HOLD),
      .ID_W(32), .CHECK_ID(1'b1), .EXPECT_ID(GOOD_ID)
   ) dut_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
      .busy_o(busy_o), .done_o(done_o), .id_o(id_o),
      .tck_o(tck_o), .tms_o(tms_o), .tdi_o(tdi_o), .tdo_i(tdo_i)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // Driver: expected scans in script order.
   task automatic push_script(input bit full);
      exp_q.push_back('{is_ir: 1'b0, len: 32, val: 32'h0, req: "R3"});
      if (full) begin
         exp_q.push_back('{is_ir: 1'b1, len: 8,  val: 32'h05,   req: "R4"});
         exp_q.push_back('{is_ir: 1'b0, len: 4,  val: 32'h1,    req: "R4"});
         exp_q.push_back('{is_ir: 1'b1, len: 8,  val: 32'h09,   req: "R5"});
         exp_q.push_back('{is_ir: 1'b0, len: 16, val: 32'h0001, req: "R6"});
         exp_q.push_back('{is_ir: 1'b0, len: 16, val: 32'h0000, req: "R6"});
      end
   endtask

   // Monitor: compares every completed scan against the queue head.
   task automatic see_scan(input bit is_ir, input int len, input logic [31:0] val);
      scan_item_t it;
      scan_cnt++;
      if (!is_ir && len == 16) begin
         if (val == 32'h1) t_set = cyc;
         else              t_clr = cyc;
      end
      if (exp_q.size() == 0) begin
         chk(1'b0, "R3", "unexpected scan value", val, 0);
      end else begin
         it = exp_q.pop_front();
         chk(it.is_ir == is_ir && it.len == len, it.req, "scan kind/length",
             {is_ir, 8'(len)}, {it.is_ir, 8'(it.len)});
         chk(it.val == val, it.req, "scan value", val, it.val);
      end
   endtask

   function automatic int tap_next(input int s, input logic m);
      case (s)
         TLR:   return m ? TLR   : RTI;
         RTI:   return m ? SELDR : RTI;
         SELDR: return m ? SELIR : CAPDR;
         CAPDR: return m ? EX1DR : SHDR;
         SHDR:  return m ? EX1DR : SHDR;
         EX1DR: return m ? UPDR  : PSDR;
         PSDR:  return m ? EX2DR : PSDR;
         EX2DR: return m ? UPDR  : SHDR;
         UPDR:  return m ? SELDR : RTI;
         SELIR: return m ? TLR   : CAPIR;
         CAPIR: return m ? EX1IR : SHIR;
         SHIR:  return m ? EX1IR : SHIR;
         EX1IR: return m ? UPIR  : PSIR;
         PSIR:  return m ? EX2IR : PSIR;
         EX2IR: return m ? UPIR  : SHIR;
         default: return m ? SELDR : RTI;
      endcase
   endfunction

   always @(posedge clk_i) cyc++;

   always @(posedge clk_i) if (rst_ni === 1'b1 && done_o === 1'b1) done_cnt++;

   // Target TAP model.
   always @(posedge tck_o) begin
      int nx;
      if (rst_ni === 1'b1) begin
         case (tap_st)
            CAPDR: begin dsh = id_sel ? model_id : 32'h0; dn = 0; end
            CAPIR: begin dsh = 32'h1; dn = 0; end
            SHDR, SHIR: begin dsh = {tdi_o, dsh[31:1]}; dn++; end
            UPDR, UPIR: if (armed) see_scan(tap_st == UPIR, dn, (dn > 0) ? (dsh >> (32 - dn)) : 32'h0);
            default: ;
         endcase
         if (tap_st == UPIR) id_sel = 0;
         nx = tap_next(tap_st, tms_o);
         if (nx == TLR && tap_st != TLR) begin
            armed = 1;
            tlr_hits++;
         end
         if (nx == TLR) id_sel = 1;
         tap_st = nx;
      end
   end

   always @(negedge tck_o) tdo_i = (tap_st == SHDR || tap_st == SHIR) ? dsh[0] : 1'b0;

   // R13 pin-stability watcher
   always @(negedge clk_i) begin
      if (rst_ni === 1'b1 && tck_o === 1'b1 && (tms_o !== prev_tms || tdi_o !== prev_tdi)) pin_bad++;
      prev_tms = tms_o;
      prev_tdi = tdi_o;
   end

   task automatic wait_done(output bit seen);
      seen = 0;
      for (int i = 0; i < 20000 && !seen; i++) begin
         @(negedge clk_i);
         if (done_o) seen = 1;
      end
   endtask

   task automatic pulse_start();
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
   endtask

   initial begin : watchdog
      #4_000_000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 0x%0h expected 0x%0h", cyc, 200000);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : main
      bit seen;
      int sc0;
      rst_ni   = 1'b0;
      start_i  = 1'b0;
      model_id = GOOD_ID;
      repeat (5) @(negedge clk_i);
      // R1 reset state
      chk(tck_o == 1'b1, "R1", "tck in reset", tck_o, 1);
      chk(busy_o == 1'b0, "R1", "busy in reset", busy_o, 0);
      chk(done_o == 1'b0, "R1", "done in reset", done_o, 0);
      chk(id_o == 32'h0, "R1", "id in reset", id_o, 0);
      rst_ni = 1'b1;
      repeat (3) @(negedge clk_i);

      // Run A: full script with a matching ID, plus a stray start mid-run (R10)
      push_script(1'b1);
      pulse_start();
      repeat (60) @(negedge clk_i);
      chk(busy_o == 1'b1, "R10", "busy mid-run", busy_o, 1);
      pulse_start();
      wait_done(seen);
      chk(seen, "R9", "done pulse seen", seen, 1);
      chk(busy_o == 1'b0, "R9", "busy low at done", busy_o, 0);
      repeat (100) @(negedge clk_i);
      chk(done_o == 1'b0, "R9", "done low after pulse", done_o, 0);
      chk(tap_st == RTI, "R9", "TAP left in Run-Test/Idle", tap_st, RTI);
      chk(tlr_hits == 1, "R2", "Test-Logic-Reset entries", tlr_hits, 1);
      chk(exp_q.size() == 0, "R6", "scans outstanding", exp_q.size(), 0);
      chk(done_cnt == 1, "R10", "done pulses after stray start", done_cnt, 1);
      chk(scan_cnt == 6, "R10", "scan count after stray start", scan_cnt, 6);
      chk(id_o == GOOD_ID, "R7", "captured id held", id_o, GOOD_ID);
      chk(t_clr - t_set >= HOLD, "R8", "hold lower bound", t_clr - t_set, HOLD);
      chk(t_clr - t_set <= HOLD + 60 * HALF, "R8", "hold upper bound", t_clr - t_set, HOLD + 60 * HALF);

      // Run B: ID mismatch ends the run after the ID scan (R11)
      model_id = BAD_ID;
      sc0 = scan_cnt;
      push_script(1'b0);
      pulse_start();
      chk(id_o == 32'h0, "R7", "id cleared at start", id_o, 0);
      wait_done(seen);
      chk(seen, "R11", "done after mismatch", seen, 1);
      repeat (200) @(negedge clk_i);
      chk(scan_cnt == sc0 + 1, "R11", "scans after mismatch", scan_cnt, sc0 + 1);
      chk(exp_q.size() == 0, "R11", "mismatch scans outstanding", exp_q.size(), 0);
      chk(id_o == BAD_ID, "R11", "mismatched id shown", id_o, BAD_ID);
      chk(done_cnt == 2, "R11", "done pulses", done_cnt, 2);
      chk(tap_st == RTI, "R11", "TAP idle after abort", tap_st, RTI);

      // Run C: start in the done cycle (R12)
      model_id = GOOD_ID;
      push_script(1'b1);
      push_script(1'b1);
      pulse_start();
      wait_done(seen);
      chk(seen, "R12", "first done", seen, 1);
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      chk(busy_o == 1'b1, "R12", "busy after start in done cycle", busy_o, 1);
      chk(id_o == 32'h0, "R12", "id cleared by back-to-back start", id_o, 0);
      wait_done(seen);
      chk(seen, "R12", "second done", seen, 1);
      repeat (100) @(negedge clk_i);
      chk(exp_q.size() == 0, "R12", "back-to-back scans outstanding", exp_q.size(), 0);
      chk(done_cnt == 4, "R12", "done pulses total", done_cnt, 4);
      chk(id_o == GOOD_ID, "R3", "id read LSB first", id_o, GOOD_ID);
      chk(tlr_hits == 4, "R2", "Test-Logic-Reset entries total", tlr_hits, 4);
      chk(pin_bad == 0, "R13", "pin changes while TCK high", pin_bad, 0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule